// File: doc/BRIEF.md
# Multiplexed BCD Digit Scanner with Leading-Zero Blanking

This block takes eight latched BCD digits and presents them one at a time on a shared 4-bit bus. It also drives a matching set of eight digit strobes, so a display can be refreshed in time-multiplexed fashion. A slow, free-running scan clock from outside the system clock domain moves the scan one digit per falling edge. The scan starts at the most significant digit, moves toward the least significant, and then starts again.

A blank output suppresses leading zeros. At the start of every pass the blanking state is armed. It stays armed through zero digits until one of three things releases it: a nonzero digit, a decimal-point request during the current digit, or a set overflow latch. The least significant digit is never blanked, so a value of zero still shows one `0`. A scan reset input holds the scan at the most significant digit. That input is synchronized, so it may be released at any time relative to the scan clock.

Top module: `bcd_scan_mux`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it, `strobe_o` is 8'h80 (MSD), `bcd_o` is 0 and `blank_o` is 1.
- R2: Each falling edge of `scan_clk_i` moves the scan by exactly one digit. The new strobe and digit appear on the 4th rising `clk` edge after the falling edge. A rising edge of `scan_clk_i` changes nothing.
- R3: Strobes advance from bit 7 (MSD) down to bit 0 (LSD). After bit 0 the next falling edge returns to bit 7.
- R4: Exactly one bit of `strobe_o` is high at all times, and the strobes are active high.
- R5: `bcd_o` equals digit k of `digits_i` while `strobe_o[k]` is high. Digit k occupies bits [4k+3:4k], so k=0 is the LSD.
- R6: While `scan_rst_i` is high, the scan stays at the MSD and scan-clock edges are ignored. After release, the first falling edge moves to bit 6.
- R7: `blank_o` is high for a digit when that digit and every more significant digit of the current pass are zero. It is low from the first nonzero digit onward.
- R8: `blank_o` is never high while `strobe_o[0]` is high.
- R9: `dp_i` high during a digit unblanks that digit and every later digit of the same pass.
- R10: `ovf_i` high unblanks every digit. `blank_o` is low one clock after `ovf_i` is seen high.
- R11: Blanking re-arms at the MSD of every pass, so a second pass blanks the same leading zeros as the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_clk_i | input | 1 | Asynchronous scan clock; the scan moves on its falling edge |
| scan_rst_i | input | 1 | Asynchronous scan reset, high holds the MSD |
| digits_i | input | 32 | Eight latched BCD digits, digit k at bits [4k+3:4k] |
| dp_i | input | 1 | Decimal-point request, unblanks from the current digit on |
| ovf_i | input | 1 | Overflow latch, unblanks the whole display |
| strobe_o | output | 8 | One-hot digit strobes, bit 7 = MSD |
| bcd_o | output | 4 | BCD value of the strobed digit |
| blank_o | output | 1 | Blank request for the strobed digit |

## Verification
A scan-clock falling edge takes two synchronizer flops and one edge-detect flop before the position register moves. The registered outputs then change on the 4th rising clock edge. The bench checks that nothing has changed on the falling clock edge after the 3rd rising edge, and that the new strobe is present one edge later. Blanking depends on the live decimal-point and overflow inputs through one output register. For that reason every per-digit sample is taken three clock cycles after the digit has settled, and the decimal-point input is held through the next scan edge so that the blanking state captures it.

// File: rtl/bcd_scan_pkg.sv
package bcd_scan_pkg;
  localparam int BCD_W = 4;
  typedef logic [BCD_W-1:0] bcd_t;
endpackage

// File: rtl/scan_edge_sync.sv
module scan_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scan_clk_i,
  input  logic scan_rst_i,
  output logic adv_o,
  output logic hold_o
);
  // sclk_sr[STAGES-1] is the synchronized level, sclk_sr[STAGES] its previous value
  logic [STAGES:0]   sclk_sr;
  logic [STAGES-1:0] srst_sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_sr <= '0;
      srst_sr <= '0;
    end else begin
      sclk_sr[0] <= scan_clk_i;
      srst_sr[0] <= scan_rst_i;
      for (int i = 1; i <= STAGES; i++) sclk_sr[i] <= sclk_sr[i-1];
      for (int i = 1; i < STAGES; i++)  srst_sr[i] <= srst_sr[i-1];
    end
  end

  assign adv_o  = sclk_sr[STAGES] & ~sclk_sr[STAGES-1];
  assign hold_o = srst_sr[STAGES-1];

  // R2: a falling edge yields a single-cycle advance pulse
  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    adv_o |=> !adv_o);
endmodule

// File: rtl/scan_pos_counter.sv
module scan_pos_counter #(
  parameter int NUM_DIGITS = 8,
  localparam int POS_W = $clog2(NUM_DIGITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv_i,
  input  logic             hold_i,
  output logic [POS_W-1:0] pos_o
);
  localparam logic [POS_W-1:0] MSD = POS_W'(NUM_DIGITS - 1);

  logic [POS_W-1:0] pos_q;

  always_ff @(posedge clk) begin
    if (rst || hold_i)      pos_q <= MSD;
    else if (adv_i)         pos_q <= (pos_q == '0) ? MSD : pos_q - 1'b1;
  end

  assign pos_o = pos_q;

  assert_scan_order_R3: assert property (@(posedge clk) disable iff (rst)
    (adv_i && !hold_i) |=> (pos_q == (($past(pos_q) == '0) ? MSD : POS_W'($past(pos_q) - 1'b1))));

  assert_hold_msd_R6: assert property (@(posedge clk) disable iff (rst)
    hold_i |=> (pos_q == MSD));

  assert_no_spurious_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!adv_i && !hold_i) |=> $stable(pos_q));
endmodule

// File: rtl/blank_ctrl.sv
module blank_ctrl
  import bcd_scan_pkg::*;
#(
  parameter int NUM_DIGITS = 8,
  localparam int POS_W = $clog2(NUM_DIGITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv_i,
  input  logic             hold_i,
  input  logic [POS_W-1:0] pos_i,
  input  bcd_t             digit_i,
  input  logic             dp_i,
  input  logic             ovf_i,
  output logic             cur_blank_o
);
  // armed: every more significant digit of this pass was suppressed
  logic armed_q;

  assign cur_blank_o = armed_q && (digit_i == '0) && !dp_i && !ovf_i && (pos_i != '0);

  always_ff @(posedge clk) begin
    if (rst || hold_i)  armed_q <= 1'b1;
    else if (adv_i)     armed_q <= (pos_i == '0) ? 1'b1 : cur_blank_o;
  end

  // R11: leaving the LSD re-arms suppression for the next pass
  assert_rearm_R11: assert property (@(posedge clk) disable iff (rst)
    (adv_i && pos_i == '0) |=> armed_q);
endmodule

// File: rtl/bcd_scan_mux.sv
module bcd_scan_mux
  import bcd_scan_pkg::*;
#(
  parameter int NUM_DIGITS  = 8,
  parameter int SYNC_STAGES = 2,
  localparam int POS_W = $clog2(NUM_DIGITS)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        scan_clk_i,
  input  logic                        scan_rst_i,
  input  logic [NUM_DIGITS*BCD_W-1:0] digits_i,
  input  logic                        dp_i,
  input  logic                        ovf_i,
  output logic [NUM_DIGITS-1:0]       strobe_o,
  output logic [BCD_W-1:0]            bcd_o,
  output logic                        blank_o
);
  logic             adv, hold, cur_blank;
  logic [POS_W-1:0] pos;
  bcd_t             sel_digit;

  scan_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scan_clk_i(scan_clk_i), .scan_rst_i(scan_rst_i),
    .adv_o(adv), .hold_o(hold)
  );

  scan_pos_counter #(.NUM_DIGITS(NUM_DIGITS)) u_pos (
    .clk(clk), .rst(rst), .adv_i(adv), .hold_i(hold), .pos_o(pos)
  );

  assign sel_digit = digits_i[pos*BCD_W +: BCD_W];

  blank_ctrl #(.NUM_DIGITS(NUM_DIGITS)) u_blank (
    .clk(clk), .rst(rst), .adv_i(adv), .hold_i(hold), .pos_i(pos),
    .digit_i(sel_digit), .dp_i(dp_i), .ovf_i(ovf_i), .cur_blank_o(cur_blank)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_o <= NUM_DIGITS'(1) << (NUM_DIGITS - 1);
      bcd_o    <= '0;
      blank_o  <= 1'b1;
    end else begin
      strobe_o <= NUM_DIGITS'(1) << pos;
      bcd_o    <= sel_digit;
      blank_o  <= cur_blank;
    end
  end

  assert_one_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    $countones(strobe_o) == 1);

  assert_lsd_shown_R8: assert property (@(posedge clk) disable iff (rst)
    strobe_o[0] |-> !blank_o);

  assert_ovf_unblank_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ovf_i)) |-> !blank_o);
endmodule

// File: tb/tb_bcd_scan_mux.sv
module tb_bcd_scan_mux;
  logic        clk = 0;
  logic        rst = 1;
  logic        scan_clk = 0, scan_rst = 0, dp = 0, ovf = 0;
  logic [31:0] digits = '0;
  logic [7:0]  strobe;
  logic [3:0]  bcd;
  logic        blank;
  int          n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  bcd_scan_mux dut (
    .clk(clk), .rst(rst), .scan_clk_i(scan_clk), .scan_rst_i(scan_rst),
    .digits_i(digits), .dp_i(dp), .ovf_i(ovf),
    .strobe_o(strobe), .bcd_o(bcd), .blank_o(blank)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    scan_clk = 1;
    repeat (4) @(negedge clk);
    scan_clk = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic scan_reset();
    scan_rst = 1;
    repeat (5) @(negedge clk);
    scan_rst = 0;
    repeat (5) @(negedge clk);
  endtask

  function automatic bit exp_blank(input logic [31:0] d, input bit ov, input int dpp, input int p);
    if (p == 0 || ov) return 0;
    if (dpp >= 0 && p <= dpp) return 0;
    for (int k = 7; k >= p; k--) if (d[k*4 +: 4] != 0) return 0;
    return 1;
  endfunction

  // R1
  task automatic test_reset();
    rst = 1;
    repeat (3) @(negedge clk);
    check("R1 strobe", strobe, 8'h80);
    check("R1 bcd", bcd, 0);
    check("R1 blank", blank, 1);
    rst = 0;
    repeat (2) @(negedge clk);
  endtask

  // R3 R4 R5 R7 R8 R9 R10 R11
  task automatic run_scan(input logic [31:0] d, input bit ov, input int dpp, input string tag);
    digits = d; ovf = ov;
    scan_reset();
    for (int pass = 0; pass < 2; pass++) begin
      for (int p = 7; p >= 0; p--) begin
        if (p == dpp) dp = 1;
        repeat (3) @(negedge clk);
        check({tag, " R3/R4 strobe"}, strobe, 1 << p);
        check({tag, " R5 bcd"}, bcd, d[p*4 +: 4]);
        check({tag, " R7/R8/R9/R10/R11 blank"}, blank, exp_blank(d, ov, dpp, p));
        step();
        dp = 0;
      end
    end
    repeat (3) @(negedge clk);
    check({tag, " R3 wrap"}, strobe, 8'h80);
    ovf = 0;
  endtask

  // R2 latency and rising-edge immunity
  task automatic test_latency();
    digits = 32'h87654321;
    scan_reset();
    scan_clk = 1;
    repeat (6) @(negedge clk);
    check("R2 rising edge ignored", strobe, 8'h80);
    scan_clk = 0;
    repeat (3) @(negedge clk);
    check("R2 not before 4th edge", strobe, 8'h80);
    @(negedge clk);
    check("R2 at 4th edge strobe", strobe, 8'h40);
    check("R2 at 4th edge bcd", bcd, 7);
    repeat (4) @(negedge clk);
  endtask

  // R6
  task automatic test_scan_rst();
    digits = 32'h87654321;
    scan_reset();
    step(); step();
    check("R6 pre", strobe, 8'h20);
    scan_rst = 1;
    repeat (5) @(negedge clk);
    check("R6 forced MSD", strobe, 8'h80);
    step(); step();
    check("R6 held", strobe, 8'h80);
    check("R6 held bcd", bcd, 8);
    scan_rst = 0;
    repeat (3) @(negedge clk);
    step();
    check("R6 resumes", strobe, 8'h40);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    test_reset();
    test_latency();
    test_scan_rst();
    run_scan(32'h00012340, 0, -1, "lead zeros");
    run_scan(32'h00000000, 0, -1, "all zero");
    run_scan(32'h98765432, 0, -1, "full");
    run_scan(32'h00000000, 1, -1, "overflow");
    run_scan(32'h00000500, 0, 4, "dp early");
    run_scan(32'h00300000, 0, 2, "dp late");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule